// File: doc/BRIEF.md
# Translation Buffer with Fault Classification

This block translates 32-bit virtual addresses for fetch, load and store accesses through a fully associative table of 32 page entries, 4 KB pages. Each cycle it takes an address, an access kind, an access size and a user-mode flag. It returns a physical address, a lookup-hit flag and a fault cause code. The top quarter of the space is mapped directly in kernel mode and is never looked up. Every other address a mode may reach is looked up.

Faults are classified in a fixed order: misalignment, then privilege, then table miss, then invalid entry, then write protection. A miss on a lower-half (user) address also raises a separate user-miss indication, so that a fast refill handler can be entered. When a request with a fault is accepted, the block captures the faulting address for software. After a table fault it also captures the faulting page number. Software fills the table by loading an index register, a tag register and a frame register, and then pulsing an entry write.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset, index_q, entry_hi, entry_lo and bad_addr read zero. No table entry matches any address that can be looked up, so every looked-up access misses (cause 21).
- R2: A write on wr_data to the index register keeps bits 4:0. A write to the tag register keeps bits 31:12. A write to the frame register keeps bits 29:12 (frame) and bit 1 (write enable) and bit 0 (valid). All other bits read zero. Each readback appears one cycle after the write. A pulse on entry_we copies the tag and frame registers into the entry selected by the index register.
- R3: In kernel mode, an address at or above 0xC0000000 is not looked up. paddr equals vaddr with bits 31:30 cleared, hit is 0, and cause is 0.
- R4: A looked-up address that matches a valid entry, with no other fault, gives hit=1, fault=0 and cause=0. paddr is {2'b00, frame, vaddr[11:0]}.
- R5: A word access (acc_size=2) with vaddr[1:0]≠0 faults with cause 24. So does a halfword access (acc_size=1) with vaddr[0]=1. This holds for every kind: fetch=0, load=1, store=2. A byte access (acc_size=0) never faults for alignment.
- R6: A user-mode access (user_mode=1) with vaddr[31]=1 faults with cause 25.
- R7: A looked-up address that matches no entry faults with cause 21. user_miss is 1 exactly when such a miss has vaddr[31]=0.
- R8: A match on an entry whose valid bit is clear faults with cause 23. A store matching a valid entry whose write-enable bit is clear faults with cause 22. Loads and fetches ignore write enable.
- R9: When several faults apply, cause reports the first of 24, 25, 21, 23, 22. For causes 24 and 25 no lookup is made, so hit is 0. On any fault paddr is 0.
- R10: A cycle with req_valid=1 and a fault of cause 21, 22 or 23 loads entry_hi with {vaddr[31:12], 12'h000} and bad_addr with vaddr for the next cycle. A cycle with cause 24 or 25 loads bad_addr only.
- R11: A cycle with req_valid=0, or with no fault, leaves bad_addr and entry_hi unchanged (unless software writes the tag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access is real; enables fault capture |
| vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| user_mode | input | 1 | 1 = user mode |
| paddr | output | 32 | Physical address (0 on fault) |
| hit | output | 1 | A table entry matched a looked-up address |
| fault | output | 1 | Access faults |
| cause | output | 5 | Fault cause code, 0 when none |
| user_miss | output | 1 | Miss on a lower-half address |
| idx_we | input | 1 | Write index register from wr_data |
| hi_we | input | 1 | Write tag register from wr_data |
| lo_we | input | 1 | Write frame register from wr_data |
| wr_data | input | 32 | Software write data |
| entry_we | input | 1 | Copy tag/frame registers into indexed entry |
| index_q | output | 5 | Index register |
| entry_hi | output | 32 | Tag register |
| entry_lo | output | 32 | Frame register |
| bad_addr | output | 32 | Last faulting address |

## Verification
The assertions take acc_size as 0, 1 or 2 and acc_kind as 0, 1 or 2. They also assume that software never writes the tag register in the same cycle as an accepted table fault. The bench drives only those encodings. It keeps hi_we low during every lookup cycle, and it loads the table before the vector walk so that no two entries share a tag.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 18;

    typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_kind_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
    typedef enum logic [4:0] {
        CAUSE_NONE  = 5'd0,
        CAUSE_MISS  = 5'd21,
        CAUSE_WPROT = 5'd22,
        CAUSE_INVAL = 5'd23,
        CAUSE_ALIGN = 5'd24,
        CAUSE_PRIV  = 5'd25
    } cause_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             wr_en;
        logic             valid;
    } tlb_entry_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [1:0] low);
        return (sz == SZ_WORD && low != 2'b00) || (sz == SZ_HALF && low[0]);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  tlb_entry_t       wentry,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             match_o,
    output tlb_entry_t       entry_o
);
    tlb_entry_t        ent_arr [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlb_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                // R1: park each tag in the direct-mapped region, never looked up
                ent_q <= '{vpn: VPN_W'(32'hC0000 + i), pfn: '0, wr_en: 1'b0, valid: 1'b0};
            end else if (we && widx == IDX_W'(i)) begin
                ent_q <= wentry;
            end
        end
        assign ent_arr[i] = ent_q;
        assign hit_vec[i] = (ent_q.vpn == look_vpn);
    end

    always_comb begin
        match_o = 1'b0;
        entry_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match_o = 1'b1;
                entry_o = ent_arr[i];
            end
        end
    end
endmodule

// File: rtl/tlb_fault_chk.sv
module tlb_fault_chk
    import tlbx_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  acc_kind_e       kind,
    input  acc_size_e       size,
    input  logic            user,
    input  logic            match_i,
    input  tlb_entry_t      entry_i,
    output logic [VA_W-1:0] pa,
    output logic            hit_o,
    output logic            fault_o,
    output cause_e          cause_o,
    output logic            umiss_o,
    output logic            tlb_fault_o
);
    logic misal, priv, direct, lookup, miss, inval, wprot;

    always_comb begin
        misal  = is_misaligned(size, va[1:0]);
        priv   = user && va[31];
        direct = !user && va[31:30] == 2'b11;
        lookup = !misal && !priv && !direct;
        miss   = lookup && !match_i;
        inval  = lookup && match_i && !entry_i.valid;
        wprot  = lookup && match_i && entry_i.valid && kind == ACC_STORE && !entry_i.wr_en;

        // R9: fixed priority chain
        if (misal)      cause_o = CAUSE_ALIGN;
        else if (priv)  cause_o = CAUSE_PRIV;
        else if (miss)  cause_o = CAUSE_MISS;
        else if (inval) cause_o = CAUSE_INVAL;
        else if (wprot) cause_o = CAUSE_WPROT;
        else            cause_o = CAUSE_NONE;

        fault_o     = cause_o != CAUSE_NONE;
        tlb_fault_o = miss || inval || wprot;
        hit_o       = lookup && match_i;
        umiss_o     = miss && !va[31];

        if (fault_o)     pa = '0;
        else if (direct) pa = {2'b00, va[29:0]};
        else             pa = {{(VA_W-PFN_W-OFF_W){1'b0}}, entry_i.pfn, va[OFF_W-1:0]};
    end
endmodule

// File: rtl/tlb_sw_regs.sv
module tlb_sw_regs
    import tlbx_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [VA_W-1:0]  wr_data,
    input  logic             cap_en,
    input  logic             cap_tlb,
    input  logic [VA_W-1:0]  va,
    output logic [IDX_W-1:0] idx_q,
    output logic [VA_W-1:0]  hi_q,
    output logic [VA_W-1:0]  lo_q,
    output logic [VA_W-1:0]  bad_q
);
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;
    logic [1:0]       flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            vpn_q <= '0;
            pfn_q <= '0;
            flg_q <= '0;
            bad_q <= '0;
        end else begin
            if (idx_we) idx_q <= wr_data[IDX_W-1:0];
            if (lo_we) begin
                pfn_q <= wr_data[OFF_W +: PFN_W];
                flg_q <= wr_data[1:0];
            end
            if (cap_en) bad_q <= va;
            if (cap_en && cap_tlb) vpn_q <= va[VA_W-1:OFF_W];
            else if (hi_we)        vpn_q <= wr_data[VA_W-1:OFF_W];
        end
    end

    assign hi_q = {vpn_q, {OFF_W{1'b0}}};
    assign lo_q = {{(VA_W-PFN_W-OFF_W){1'b0}}, pfn_q, {(OFF_W-2){1'b0}}, flg_q};

    // R10
    bad_capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> bad_q == $past(va));
    // R10
    hi_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cap_tlb) |=> hi_q == {$past(va[VA_W-1:OFF_W]), {OFF_W{1'b0}}});
    // R11
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(bad_q));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      vaddr,
    input  logic [1:0]       acc_kind,
    input  logic [1:0]       acc_size,
    input  logic             user_mode,
    output logic [31:0]      paddr,
    output logic             hit,
    output logic             fault,
    output logic [4:0]       cause,
    output logic             user_miss,
    input  logic             idx_we,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [31:0]      wr_data,
    input  logic             entry_we,
    output logic [IDX_W-1:0] index_q,
    output logic [31:0]      entry_hi,
    output logic [31:0]      entry_lo,
    output logic [31:0]      bad_addr
);
    logic       match;
    tlb_entry_t m_entry, w_entry;
    cause_e     cause_e_w;
    logic       tlb_fault;

    assign w_entry = '{vpn: entry_hi[VA_W-1:OFF_W], pfn: entry_lo[OFF_W +: PFN_W],
                       wr_en: entry_lo[1], valid: entry_lo[0]};

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk(clk), .rst(rst), .we(entry_we), .widx(index_q), .wentry(w_entry),
        .look_vpn(vaddr[VA_W-1:OFF_W]), .match_o(match), .entry_o(m_entry)
    );

    tlb_fault_chk u_chk (
        .va(vaddr), .kind(acc_kind_e'(acc_kind)), .size(acc_size_e'(acc_size)),
        .user(user_mode), .match_i(match), .entry_i(m_entry), .pa(paddr),
        .hit_o(hit), .fault_o(fault), .cause_o(cause_e_w), .umiss_o(user_miss),
        .tlb_fault_o(tlb_fault)
    );
    assign cause = cause_e_w;

    tlb_sw_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .idx_we(idx_we), .hi_we(hi_we), .lo_we(lo_we),
        .wr_data(wr_data), .cap_en(req_valid && fault), .cap_tlb(tlb_fault),
        .va(vaddr), .idx_q(index_q), .hi_q(entry_hi), .lo_q(entry_lo), .bad_q(bad_addr)
    );

    // R5
    align_word_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_size == 2'd2 && vaddr[1:0] != 2'b00) |-> (cause == 5'd24 && !hit));
    // R6
    priv_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (user_mode && vaddr[31] && acc_size == 2'd0) |-> cause == 5'd25);
    // R7
    umiss_chk: assert property (@(posedge clk) disable iff (rst)
        user_miss |-> (cause == 5'd21 && !vaddr[31] && !hit));
    // R8
    wprot_store_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == 5'd22) |-> (acc_kind == 2'd2 && hit && paddr == 32'h0));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] vaddr;
    logic [1:0]  acc_kind, acc_size;
    logic        user_mode;
    logic [31:0] paddr;
    logic        hit, fault, user_miss;
    logic [4:0]  cause;
    logic        idx_we, hi_we, lo_we, entry_we;
    logic [31:0] wr_data;
    logic [4:0]  index_q;
    logic [31:0] entry_hi, entry_lo, bad_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
        .acc_kind(acc_kind), .acc_size(acc_size), .user_mode(user_mode),
        .paddr(paddr), .hit(hit), .fault(fault), .cause(cause), .user_miss(user_miss),
        .idx_we(idx_we), .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data),
        .entry_we(entry_we), .index_q(index_q), .entry_hi(entry_hi),
        .entry_lo(entry_lo), .bad_addr(bad_addr)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic [1:0]  size;
        logic        user;
        logic [4:0]  cause;
        logic [31:0] pa;
        logic        hit;
        logic        umiss;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h00001ABC, 2'd1, 2'd2, 1'b1, 5'd0,  32'h00123ABC, 1'b1, 1'b0, 8'd4}, // R4
        '{32'h00001ABE, 2'd2, 2'd1, 1'b0, 5'd0,  32'h00123ABE, 1'b1, 1'b0, 8'd4},
        '{32'h00001ABD, 2'd1, 2'd0, 1'b0, 5'd0,  32'h00123ABD, 1'b1, 1'b0, 8'd5}, // R5 byte
        '{32'h00001ABE, 2'd0, 2'd2, 1'b0, 5'd24, 32'h0,        1'b0, 1'b0, 8'd5},
        '{32'h00001ABD, 2'd1, 2'd1, 1'b0, 5'd24, 32'h0,        1'b0, 1'b0, 8'd5},
        '{32'h80000000, 2'd1, 2'd2, 1'b1, 5'd25, 32'h0,        1'b0, 1'b0, 8'd6}, // R6
        '{32'hC0001234, 2'd1, 2'd2, 1'b0, 5'd0,  32'h00001234, 1'b0, 1'b0, 8'd3}, // R3
        '{32'h00009000, 2'd1, 2'd2, 1'b0, 5'd21, 32'h0,        1'b0, 1'b1, 8'd7}, // R7
        '{32'h80009000, 2'd1, 2'd2, 1'b0, 5'd21, 32'h0,        1'b0, 1'b0, 8'd7},
        '{32'h00003000, 2'd1, 2'd2, 1'b0, 5'd23, 32'h0,        1'b1, 1'b0, 8'd8}, // R8
        '{32'h00002000, 2'd2, 2'd2, 1'b0, 5'd22, 32'h0,        1'b1, 1'b0, 8'd8},
        '{32'h00002000, 2'd1, 2'd2, 1'b0, 5'd0,  32'h00456000, 1'b1, 1'b0, 8'd8},
        '{32'h80004010, 2'd2, 2'd2, 1'b0, 5'd0,  32'h3FFFF010, 1'b1, 1'b0, 8'd4},
        '{32'h00005FFC, 2'd0, 2'd2, 1'b1, 5'd0,  32'h00777FFC, 1'b1, 1'b0, 8'd4},
        '{32'h80004011, 2'd1, 2'd2, 1'b1, 5'd24, 32'h0,        1'b0, 1'b0, 8'd9}, // R9
        '{32'h00003002, 2'd1, 2'd2, 1'b0, 5'd24, 32'h0,        1'b0, 1'b0, 8'd9},
        '{32'hC0000003, 2'd0, 2'd2, 1'b1, 5'd24, 32'h0,        1'b0, 1'b0, 8'd9},
        '{32'h00003000, 2'd2, 2'd2, 1'b0, 5'd23, 32'h0,        1'b1, 1'b0, 8'd9}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_data = d;
        idx_we = (sel == 0); hi_we = (sel == 1); lo_we = (sel == 2); entry_we = (sel == 3);
        @(negedge clk);
        idx_we = 0; hi_we = 0; lo_we = 0; entry_we = 0;
    endtask

    task automatic prog(input logic [31:0] idx, input logic [31:0] hi_v, input logic [31:0] lo_v);
        sw_write(1, hi_v);
        sw_write(2, lo_v);
        sw_write(0, idx);
        sw_write(3, 32'h0);
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] k, input logic [1:0] s,
                        input logic u, input logic rv);
        @(negedge clk);
        vaddr = va; acc_kind = k; acc_size = s; user_mode = u; req_valid = rv;
        #5;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] exp_bad, exp_hi;
        rst = 1; req_valid = 0; vaddr = 0; acc_kind = 0; acc_size = 0; user_mode = 0;
        idx_we = 0; hi_we = 0; lo_we = 0; entry_we = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1", "index", {27'h0, index_q}, 32'h0);
        chk("R1", "entry_hi", entry_hi, 32'h0);
        chk("R1", "entry_lo", entry_lo, 32'h0);
        chk("R1", "bad_addr", bad_addr, 32'h0);
        look(32'h00001000, 2'd1, 2'd2, 1'b0, 1'b0);
        chk("R1", "flushed user lookup cause", {27'h0, cause}, 32'd21);
        look(32'h80000000, 2'd1, 2'd2, 1'b0, 1'b0);
        chk("R1", "flushed kernel lookup cause", {27'h0, cause}, 32'd21);

        // R2 register masking and entry write
        prog(32'hFFFFFFE3, 32'h80004FFF, 32'hFFFFFFFF);
        chk("R2", "index mask", {27'h0, index_q}, 32'h3);
        chk("R2", "hi mask", entry_hi, 32'h80004000);
        chk("R2", "lo mask", entry_lo, 32'h3FFFF003);
        prog(32'd0,  32'h00001000, 32'h00123003);
        prog(32'd1,  32'h00002000, 32'h00456001);
        prog(32'd2,  32'h00003000, 32'h3FFFF000);
        prog(32'd31, 32'h00005000, 32'h00777003);
        chk("R2", "index 31", {27'h0, index_q}, 32'd31);
        exp_hi  = 32'h00005000;
        exp_bad = 32'h0;

        // vector walk: R3..R10
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            look(VECS[i].va, VECS[i].kind, VECS[i].size, VECS[i].user, 1'b1);
            chk(rq, $sformatf("v%0d cause", i), {27'h0, cause}, {27'h0, VECS[i].cause});
            chk(rq, $sformatf("v%0d fault", i), {31'h0, fault}, {31'h0, (VECS[i].cause != 0)});
            chk(rq, $sformatf("v%0d paddr", i), paddr, VECS[i].pa);
            chk(rq, $sformatf("v%0d hit", i), {31'h0, hit}, {31'h0, VECS[i].hit});
            chk(rq, $sformatf("v%0d user_miss", i), {31'h0, user_miss}, {31'h0, VECS[i].umiss});
            if (VECS[i].cause != 0) exp_bad = VECS[i].va;
            if (VECS[i].cause inside {5'd21, 5'd22, 5'd23}) exp_hi = {VECS[i].va[31:12], 12'h0};
            @(negedge clk);
            req_valid = 0;
            chk("R10", $sformatf("v%0d bad_addr", i), bad_addr, exp_bad);
            chk("R11", $sformatf("v%0d entry_hi", i), entry_hi, exp_hi);
        end

        // R11: fault with req_valid low captures nothing
        look(32'h7000A000, 2'd1, 2'd2, 1'b0, 1'b0);
        chk("R11", "unrequested miss cause", {27'h0, cause}, 32'd21);
        @(negedge clk);
        chk("R11", "bad_addr held", bad_addr, exp_bad);
        chk("R11", "entry_hi held", entry_hi, exp_hi);

        // R10: alignment fault updates bad only
        look(32'h00001001, 2'd2, 2'd1, 1'b0, 1'b1);
        @(negedge clk);
        req_valid = 0;
        chk("R10", "align bad_addr", bad_addr, 32'h00001001);
        chk("R10", "align leaves entry_hi", entry_hi, exp_hi);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule